// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined Bus Master

This block drives the address phase of a bus master on a pipelined AHB-style bus. A client presents a burst request (start address, transfer direction, beat size, burst type, protection attributes and, for undefined-length bursts, a beat count) together with a one-cycle start strobe. The sequencer latches that request, then drives the transfer type, address and control outputs for every beat. It advances only on cycles where the bus reports ready.

The opening beat of a burst is marked as a fresh transfer, and every following beat is marked as a continuation. Addresses step by the beat size, either linearly or wrapping inside an aligned block. An incrementing burst is never allowed to run across a 1 KB address boundary. The beat that would land in the new 1 KB region is instead re-issued as an opening beat, and a fixed-length incrementing type is relabelled as undefined-length from that point on. Once the final beat has been accepted, the bus is returned to idle and a one-cycle completion pulse is raised.

The controller has three states. `S_IDLE` waits for a start strobe and moves to `S_OPEN`. `S_OPEN` drives an opening beat. `S_CONT` drives a continuation beat. From `S_OPEN` or `S_CONT`, an accepted beat leads to one of three places: back to `S_IDLE` if it was the last beat, to `S_OPEN` if the next address crosses a 1 KB boundary, and to `S_CONT` otherwise. A stalled beat stays in its state.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `htrans` is IDLE (2'b00) and `done` is low.
- R2: One cycle after a start strobe is accepted, `htrans` is NONSEQ (2'b10) and `haddr` is the requested start address. Later beats of the same burst are SEQ (2'b11), except where R7 applies, and a SEQ beat never follows an IDLE cycle.
- R3: `hwrite`, `hsize` and `hprot` keep the values latched at the start for the whole burst. Changes on the request inputs while a burst runs have no effect on them.
- R4: For SINGLE, INCR and INCRn bursts, each accepted beat is followed by the address plus 2^`hsize`.
- R5: For WRAPn bursts, with block = n × 2^`hsize` bytes, the next address is base(addr) + ((addr + 2^`hsize`) mod block), where base is addr rounded down to a multiple of block.
- R6: The number of beats follows `hburst`: SINGLE=0 gives 1, INCR=1 gives `req_len` (0 counts as 1), WRAP4=2 and INCR4=3 give 4, WRAP8=4 and INCR8=5 give 8, WRAP16=6 and INCR16=7 give 16.
- R7: When an incrementing step would change address bits [31:10], that beat is issued as NONSEQ. If the burst type is INCR4, INCR8 or INCR16, `hburst` reads INCR (1) from that beat to the end of the burst. No SEQ beat ever changes address bits [31:10].
- R8: While a beat is driven and `hready` is low, `htrans`, `haddr` and the control outputs are held and no beat is consumed.
- R9: In the cycle after the final beat is accepted, `htrans` is IDLE and `done` is high. `done` is low again in the following cycle, and it is low during the beats.
- R10: A start strobe that arrives while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start strobe; only accepted while idle |
| req_addr | input | ADDR_W | Start address, aligned to the beat size |
| req_write | input | 1 | Direction: 1 = write |
| req_size | input | 3 | Beat size as log2 of the byte count |
| req_burst | input | 3 | Burst type, encoded as in R6 |
| req_prot | input | 4 | Protection attributes |
| req_len | input | LEN_W | Beat count for INCR bursts |
| hready | input | 1 | Bus ready; the current beat is accepted when high |
| htrans | output | 2 | Transfer type: IDLE, NONSEQ or SEQ |
| haddr | output | ADDR_W | Beat address |
| hwrite | output | 1 | Latched direction |
| hsize | output | 3 | Latched beat size |
| hburst | output | 3 | Burst type, relabelled after a split (R7) |
| hprot | output | 4 | Latched protection |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench covers every burst type with every beat size from byte to word. Each combination starts from a 1 KB-aligned address, from an address just below a 1 KB boundary, from a mid-block address, and from a misaligned-in-block address. This separates linear stepping from wrap arithmetic, and a wrap that never leaves its block from an incrementing burst that must be split.

Each combination runs twice: once with `hready` held high, and once with a stall every third cycle. The stalled run separates beat consumption from clock counting. Throughout every burst, conflicting start strobes and altered request fields are driven, so that any leakage of the request into a burst in progress shows up on the outputs. A long INCR burst crosses several 1 KB boundaries in one request.

// File: rtl/bag_pkg.sv
package bag_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'd0,
        BT_INCR   = 3'd1,
        BT_WRAP4  = 3'd2,
        BT_INCR4  = 3'd3,
        BT_WRAP8  = 3'd4,
        BT_INCR8  = 3'd5,
        BT_WRAP16 = 3'd6,
        BT_INCR16 = 3'd7
    } burst_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OPEN,
        S_CONT
    } state_e;

    // Wrapping types are the even, non-zero codes.
    function automatic logic is_wrap(input logic [2:0] b);
        return (b != 3'd0) && !b[0];
    endfunction

    // Fixed-length incrementing types.
    function automatic logic is_fixed_incr(input logic [2:0] b);
        return (b == BT_INCR4) || (b == BT_INCR8) || (b == BT_INCR16);
    endfunction

endpackage

// File: rtl/bag_beat_count.sv
module bag_beat_count
    import bag_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int CNT_W = 10
) (
    input  logic [2:0]       burst,
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] beats
);
    always_comb begin
        unique case (burst)
            BT_SINGLE:           beats = CNT_W'(1);
            BT_INCR:             beats = (len == '0) ? CNT_W'(1) : CNT_W'(len);
            BT_WRAP4, BT_INCR4:  beats = CNT_W'(4);
            BT_WRAP8, BT_INCR8:  beats = CNT_W'(8);
            default:             beats = CNT_W'(16);
        endcase
    end
endmodule

// File: rtl/bag_addr_step.sv
module bag_addr_step
    import bag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int KB_LOG2 = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [2:0]        burst,
    output logic [ADDR_W-1:0] next_addr,
    output logic              crosses
);
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] linear;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] wrapped;
    logic [4:0]        wrap_beats;

    always_comb begin
        unique case (burst)
            BT_WRAP4:  wrap_beats = 5'd4;
            BT_WRAP8:  wrap_beats = 5'd8;
            BT_WRAP16: wrap_beats = 5'd16;
            default:   wrap_beats = 5'd1;
        endcase
        stride    = ADDR_W'(1) << size;
        linear    = addr + stride;
        mask      = (ADDR_W'(wrap_beats) << size) - ADDR_W'(1);
        wrapped   = (addr & ~mask) | (linear & mask);
        next_addr = is_wrap(burst) ? wrapped : linear;
        crosses   = !is_wrap(burst) &&
                    (linear[ADDR_W-1:KB_LOG2] != addr[ADDR_W-1:KB_LOG2]);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 10,
    parameter int KB_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [2:0]        req_size,
    input  logic [2:0]        req_burst,
    input  logic [3:0]        req_prot,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              hready,
    output logic [1:0]        htrans,
    output logic [ADDR_W-1:0] haddr,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst,
    output logic [3:0]        hprot,
    output logic              done
);
    localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [2:0]        size_q;
    logic [2:0]        burst_q;
    logic [3:0]        prot_q;
    logic [CNT_W-1:0]  left_q;
    logic              done_q;

    logic [CNT_W-1:0]  req_beats;
    logic [ADDR_W-1:0] step_addr;
    logic              step_cross;

    logic start_ok, beat_acc, last_beat;

    assign start_ok  = req_start && (state_q == S_IDLE);
    assign beat_acc  = (state_q != S_IDLE) && hready;
    assign last_beat = (left_q == CNT_W'(1));

    bag_beat_count #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_count (
        .burst (req_burst),
        .len   (req_len),
        .beats (req_beats)
    );

    bag_addr_step #(.ADDR_W(ADDR_W), .KB_LOG2(KB_LOG2)) u_step (
        .addr      (addr_q),
        .size      (size_q),
        .burst     (burst_q),
        .next_addr (step_addr),
        .crosses   (step_cross)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_ok) state_d = S_OPEN;
            S_OPEN, S_CONT: begin
                if (beat_acc) begin
                    if (last_beat)       state_d = S_IDLE;
                    else if (step_cross) state_d = S_OPEN;
                    else                 state_d = S_CONT;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Burst parameters, address and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            size_q  <= 3'd0;
            burst_q <= 3'd0;
            prot_q  <= 4'd0;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= beat_acc && last_beat;
            if (start_ok) begin
                addr_q  <= req_addr;
                write_q <= req_write;
                size_q  <= req_size;
                burst_q <= req_burst;
                prot_q  <= req_prot;
                left_q  <= req_beats;
            end else if (beat_acc && !last_beat) begin
                addr_q <= step_addr;
                left_q <= left_q - CNT_W'(1);
                if (step_cross && is_fixed_incr(burst_q)) burst_q <= BT_INCR;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            S_OPEN:  htrans = TR_NONSEQ;
            S_CONT:  htrans = TR_SEQ;
            default: htrans = TR_IDLE;
        endcase
        haddr  = addr_q;
        hwrite = write_q;
        hsize  = size_q;
        hburst = burst_q;
        hprot  = prot_q;
        done   = done_q;
    end

    // ---------------- assertions ----------------
    logic [ADDR_W-1:0] chk_block;
    always_comb begin
        unique case (hburst)
            BT_WRAP4:  chk_block = ADDR_W'(4)  << hsize;
            BT_WRAP8:  chk_block = ADDR_W'(8)  << hsize;
            default:   chk_block = ADDR_W'(16) << hsize;
        endcase
    end

    p_seq_after_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ) |-> ($past(htrans) != TR_IDLE));

    p_ctrl_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ) |-> ($stable(hwrite) && $stable(hsize) &&
                                $stable(hprot) && $stable(hburst)));

    p_incr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ && $past(hready) && !is_wrap(hburst))
        |-> (haddr == $past(haddr) + (ADDR_W'(1) << hsize)));

    p_wrap_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ && is_wrap(hburst))
        |-> ((haddr / chk_block) == ($past(haddr) / chk_block)));

    p_no_kb_cross_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ)
        |-> (haddr[ADDR_W-1:KB_LOG2] == $past(haddr[ADDR_W-1:KB_LOG2])));

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != TR_IDLE && !hready) |=> ($stable(haddr) && $stable(htrans)));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (htrans == TR_IDLE));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = '0;
    logic [2:0]  req_burst = '0;
    logic [3:0]  req_prot = '0;
    logic [9:0]  req_len = '0;
    logic        hready = 1'b1;
    logic [1:0]  htrans;
    logic [31:0] haddr;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [2:0]  hburst;
    logic [3:0]  hprot;
    logic        done;

    int n_total = 0;
    int n_fail  = 0;
    int wd      = 0;

    always #4 clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_burst(req_burst),
        .req_prot(req_prot), .req_len(req_len), .hready(hready),
        .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
        .hburst(hburst), .hprot(hprot), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (time %0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog cycles=%0d expected below 150000", wd);
            summary();
            $finish;
        end
    end

    function automatic int beat_total(input logic [2:0] bt, input logic [9:0] ln);
        case (bt)
            3'd0:       return 1;
            3'd1:       return (ln == 0) ? 1 : int'(ln);
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            default:    return 16;
        endcase
    endfunction

    task automatic run(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] bt,
                       input logic [9:0] ln, input int stall);
        logic [31:0] ea, blk, stride, na;
        logic [1:0]  et;
        logic [2:0]  eb;
        logic        ew;
        logic [3:0]  ep;
        int          rem, cyc;
        bit          wrap, stalled;
        wrap   = (bt != 0) && !bt[0];
        ew     = bt[0] ^ sz[1];
        ep     = {sz, bt[1]} ^ 4'h5;
        stride = 32'd1 << sz;
        @(negedge clk);
        req_addr = a; req_size = sz; req_burst = bt; req_len = ln;
        req_write = ew; req_prot = ep; req_start = 1'b1; hready = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        ea = a; et = 2'b10; eb = bt; rem = beat_total(bt, ln); cyc = 0; stalled = 0;
        forever begin
            chk(htrans == et, stalled ? "R8 htrans" : (cyc == 0 ? "R2 htrans" : "R2/R7 htrans"), htrans, et);
            chk(haddr == ea, stalled ? "R8 haddr" : (cyc == 0 ? "R2 haddr" : (wrap ? "R5 haddr" : "R4 haddr")), haddr, ea);
            chk(hwrite == ew && hsize == sz && hprot == ep, "R3 control", {hwrite, hsize, hprot}, {ew, sz, ep});
            chk(hburst == eb, "R7 hburst", hburst, eb);
            chk(done == 1'b0, "R9 done low during burst", done, 0);
            cyc++;
            hready    = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
            // Interfering request while busy (R10 / R3)
            req_start = (cyc % 2) == 0;
            req_addr  = ~a; req_write = ~ew; req_size = sz + 3'd1;
            req_burst = ~bt; req_prot = ~ep; req_len = ln + 10'd3;
            @(negedge clk);
            stalled = !hready;
            if (hready) begin
                rem--;
                if (rem == 0) break;
                if (wrap) begin
                    blk = (bt == 3'd2 ? 32'd4 : (bt == 3'd4 ? 32'd8 : 32'd16)) << sz;
                    na  = (ea - (ea % blk)) + ((ea + stride) % blk);
                    et  = 2'b11;
                end else begin
                    na = ea + stride;
                    if ((na >> 10) != (ea >> 10)) begin
                        et = 2'b10;
                        if (bt == 3'd3 || bt == 3'd5 || bt == 3'd7) eb = 3'd1;
                    end else begin
                        et = 2'b11;
                    end
                end
                ea = na;
            end
        end
        req_start = 1'b0;
        hready    = 1'b1;
        chk(htrans == 2'b00, "R6 idle after beat count", htrans, 0);
        chk(done == 1'b1, "R9 done pulse", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", done, 0);
        chk(htrans == 2'b00, "R10 busy start ignored", htrans, 0);
    endtask

    initial begin
        logic [31:0] bases [4];
        bases[0] = 32'h0000_0000;
        bases[1] = 32'h0000_03F8;
        bases[2] = 32'h0000_2024;
        bases[3] = 32'h0001_07F4;
        repeat (3) @(negedge clk);
        chk(htrans == 2'b00, "R1 htrans reset", htrans, 0);
        chk(done == 1'b0, "R1 done reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(htrans == 2'b00, "R1 htrans after release", htrans, 0);
        for (int st = 0; st < 2; st++)
            for (int bt = 0; bt < 8; bt++)
                for (int sz = 0; sz < 3; sz++)
                    for (int ai = 0; ai < 4; ai++)
                        run(bases[ai] & ~((32'd1 << sz) - 32'd1), 3'(sz), 3'(bt),
                            10'(21 + ai), st);
        run(32'h0000_03F0, 3'd2, 3'd1, 10'd300, 1);
        run(32'h0000_0100, 3'd0, 3'd1, 10'd0, 0);
        summary();
        $finish;
    end
endmodule